// File: doc/BRIEF.md
# Double Pulse Test Sequencer

This block produces the gate command for an inductive double pulse test of one power switch in a half bridge. A single press of the start button yields one burst. The burst is a first pulse that builds up load current, an off gap, and a second pulse that switches the device at that current. The first pulse has its own width. The gap and the second pulse always share one width setting. A control bit can drop the second pulse so that the burst is a single pulse. All widths are counted in microsecond tick pulses, which come from a divider outside the block.

A desaturation input protects the device under test. Once that input is synchronized, it cuts the gate command combinationally and ends the burst. The block then reports whether the first pulse (including the gap that follows it) or the second pulse was running when the fault arrived. After every burst, whether it completed or was aborted, the block enters a lockout of fixed length with the gate held low. A start is accepted only on a fresh rising edge of the button, so holding the button down never produces a repeat run.

Top module: `dpt_sequencer`

## Requirements
- R1: The first pulse holds `gate_o` high for `pulse1_width_i` ticks. Values below 3 are treated as 3 and values above 999 as 999. With a tick on every clock this means exactly that many clock cycles. With a tick every D clocks it means between (w-1)*D+1 and w*D cycles.
- R2: When `pulse2_en_i` is 1, the gap (gate low) and the second pulse (gate high) each last `pulse2_width_i` ticks. Values below 3 are treated as 3 and values above 100 as 100.
- R3: When `pulse2_en_i` is 0, the burst is a single pulse and the lockout follows the first pulse directly.
- R4: `desat_i` passes through a two-flop synchronizer. If it is high at two consecutive rising edges while a pulse is running, `gate_o` is low after the second of those edges and the burst moves to lockout.
- R5: A fault during the first pulse or the gap sets `fault_p1_o`. A fault during the second pulse sets `fault_p2_o`. Never both are set. The flags stay latched until the next accepted start, which clears them. A fault in the gap also suppresses the second pulse.
- R6: One start request gives at most two gate pulses. A start is accepted only on a rising edge of the synchronized button. A button held through the whole burst and the lockout starts nothing more until it is released and pressed again.
- R7: After the last pulse or an abort, a lockout of `LOCKOUT_TICKS` ticks follows with `gate_o` low and `busy_o` high. `busy_o` rises together with the first pulse and falls when the lockout ends. `gate_o` is never high while `busy_o` is low.
- R8: A start edge that arrives while the synchronized `desat_i` is high is ignored. The fault flags stay unchanged.
- R9: While `rst_n` is low at a clock edge, `gate_o`, `busy_o`, `fault_p1_o` and `fault_p2_o` all go low.
- R10: From idle, `gate_o` goes high after the third rising edge at which `start_btn_i` is sampled high (two synchronizer stages plus the edge detector).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| start_btn_i | input | 1 | Start push button, asynchronous |
| desat_i | input | 1 | Desaturation fault, active high, asynchronous |
| pulse1_width_i | input | 10 | First pulse width in ticks (3..999 after clamping) |
| pulse2_width_i | input | 7 | Gap and second pulse width in ticks (3..100 after clamping) |
| pulse2_en_i | input | 1 | 1 = issue the second pulse |
| gate_o | output | 1 | Gate command to the driver |
| busy_o | output | 1 | Burst or lockout in progress |
| fault_p1_o | output | 1 | Fault seen in the first pulse or the gap |
| fault_p2_o | output | 1 | Fault seen in the second pulse |

## Verification
The gate rises three edges after the button is first sampled high. It falls two edges after desat is first sampled high. The fault flags settle one edge after that. The pulse, gap and lockout lengths follow from the tick count because each state is entered with a cleared counter. The bench drives every input just after a falling edge and samples at falling edges. It measures the high and low runs of the gate over the whole burst instead of probing single cycles. Latency checks count falling edges from the stimulus to the expected change. Flag checks wait a few cycles past the due edge.

// File: rtl/dpt_pkg.sv
// Package: shared state encoding for the double pulse test sequencer.
// Assumes nothing beyond being compiled before the modules that import it.
package dpt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE1,
        ST_GAP,
        ST_PULSE2,
        ST_LOCK
    } seq_state_e;
endpackage

// File: rtl/dpt_sync.sv
// Module: dpt_sync
// A multi-stage flop synchronizer for N independent asynchronous bits.
// Assumes each bit is a slow level (button, fault) and that STAGES >= 2.
module dpt_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    logic [N-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: shift one synchronizer stage, cleared in reset.
            always_ff @(posedge clk) begin
                if (!rst_n)      stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= async_i;
                else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/dpt_clamp.sv
// Module: dpt_clamp
// Limits an unsigned width setting to the closed range [MIN, MAX].
// Assumes MIN <= MAX and that both fit in W bits.
module dpt_clamp #(
    parameter int W   = 10,
    parameter int MIN = 3,
    parameter int MAX = 999
) (
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lim_o
);
    localparam logic [W-1:0] LO = W'(MIN);
    localparam logic [W-1:0] HI = W'(MAX);

    // Purpose: pick the nearest legal value.
    always_comb begin
        if (raw_i < LO)      lim_o = LO;
        else if (raw_i > HI) lim_o = HI;
        else                 lim_o = raw_i;
    end
endmodule

// File: rtl/dpt_tick_timer.sv
// Module: dpt_tick_timer
// Counts tick pulses. expire_o is high during the tick that completes
// target_i ticks. clear_i restarts the count from zero.
// Assumes target_i >= 1.
module dpt_tick_timer #(
    parameter int CW = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          tick_i,
    input  logic [CW-1:0] target_i,
    output logic          expire_o
);
    logic [CW-1:0] cnt_q;

    assign expire_o = tick_i && (cnt_q == target_i - CW'(1));

    // Purpose: advance on each tick, restart on clear or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (clear_i || expire_o) cnt_q <= '0;
        else if (tick_i)             cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/dpt_sequencer.sv
// Module: dpt_sequencer (top)
// One-shot double pulse burst generator with desaturation abort, fault
// origin reporting and a fixed post-burst lockout.
// Assumes us_tick_i is a single-cycle pulse, and that the start and desat
// inputs are asynchronous levels. Widths are captured when a start is accepted.
module dpt_sequencer #(
    parameter int P1_BITS       = 10,
    parameter int P2_BITS       = 7,
    parameter int P1_MIN        = 3,
    parameter int P1_MAX        = 999,
    parameter int P2_MIN        = 3,
    parameter int P2_MAX        = 100,
    parameter int LOCKOUT_TICKS = 2_000_000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               us_tick_i,
    input  logic               start_btn_i,
    input  logic               desat_i,
    input  logic [P1_BITS-1:0] pulse1_width_i,
    input  logic [P2_BITS-1:0] pulse2_width_i,
    input  logic               pulse2_en_i,
    output logic               gate_o,
    output logic               busy_o,
    output logic               fault_p1_o,
    output logic               fault_p2_o
);
    import dpt_pkg::*;

    localparam int LOCK_BITS = $clog2(LOCKOUT_TICKS + 1);
    localparam int CW = (LOCK_BITS > P1_BITS) ? LOCK_BITS : P1_BITS;

    seq_state_e         state_q, state_d;
    logic [1:0]         sync_w;
    logic               start_s, desat_s, start_prev_q, start_rise;
    logic [P1_BITS-1:0] w1_lim, w1_q;
    logic [P2_BITS-1:0] w2_lim, w2_q;
    logic               en2_q;
    logic [CW-1:0]      target;
    logic               expire, accept;
    logic               f1_q, f2_q;

    dpt_sync #(.N(2), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({desat_i, start_btn_i}),
        .sync_o  (sync_w)
    );
    assign start_s = sync_w[0];
    assign desat_s = sync_w[1];

    dpt_clamp #(.W(P1_BITS), .MIN(P1_MIN), .MAX(P1_MAX)) u_clamp1 (
        .raw_i (pulse1_width_i),
        .lim_o (w1_lim)
    );
    dpt_clamp #(.W(P2_BITS), .MIN(P2_MIN), .MAX(P2_MAX)) u_clamp2 (
        .raw_i (pulse2_width_i),
        .lim_o (w2_lim)
    );

    // Purpose: remember the previous synchronized button level for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) start_prev_q <= 1'b0;
        else        start_prev_q <= start_s;
    end
    assign start_rise = start_s && !start_prev_q;
    assign accept     = (state_q == ST_IDLE) && start_rise && !desat_s;

    // Purpose: select the tick count for the current phase.
    always_comb begin
        case (state_q)
            ST_PULSE1:         target = CW'(w1_q);
            ST_GAP, ST_PULSE2: target = CW'(w2_q);
            default:           target = CW'(LOCKOUT_TICKS);
        endcase
    end

    dpt_tick_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (state_d != state_q),
        .tick_i   (us_tick_i),
        .target_i (target),
        .expire_o (expire)
    );

    // Purpose: phase sequencing, with desat abort taking priority over expiry.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (accept) state_d = ST_PULSE1;
            ST_PULSE1: if (desat_s)     state_d = ST_LOCK;
                       else if (expire) state_d = en2_q ? ST_GAP : ST_LOCK;
            ST_GAP:    if (desat_s)     state_d = ST_LOCK;
                       else if (expire) state_d = ST_PULSE2;
            ST_PULSE2: if (desat_s || expire) state_d = ST_LOCK;
            ST_LOCK:   if (expire) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Purpose: state register and capture of the settings at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            w1_q    <= '0;
            w2_q    <= '0;
            en2_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                w1_q  <= w1_lim;
                w2_q  <= w2_lim;
                en2_q <= pulse2_en_i;
            end
        end
    end

    // Purpose: latch the fault origin, cleared only by an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f1_q <= 1'b0;
            f2_q <= 1'b0;
        end else if (accept) begin
            f1_q <= 1'b0;
            f2_q <= 1'b0;
        end else if (desat_s) begin
            if (state_q == ST_PULSE1 || state_q == ST_GAP) f1_q <= 1'b1;
            if (state_q == ST_PULSE2)                      f2_q <= 1'b1;
        end
    end

    assign gate_o     = ((state_q == ST_PULSE1) || (state_q == ST_PULSE2)) && !desat_s;
    assign busy_o     = (state_q != ST_IDLE);
    assign fault_p1_o = f1_q;
    assign fault_p2_o = f2_q;
endmodule

// File: rtl/dpt_sequencer_chk.sv
// Module: dpt_sequencer_chk
// Port-level temporal checks for dpt_sequencer, attached with bind below.
// Assumes the same clock and reset as the sequencer.
module dpt_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic desat_i,
    input logic gate_o,
    input logic busy_o,
    input logic fault_p1_o,
    input logic fault_p2_o
);
    logic [2:0] rises_q;
    logic       gate_prev_q;

    // Purpose: count gate rising edges within one busy period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rises_q     <= '0;
            gate_prev_q <= 1'b0;
        end else begin
            gate_prev_q <= gate_o;
            if (!busy_o)                     rises_q <= '0;
            else if (gate_o && !gate_prev_q) rises_q <= rises_q + 3'd1;
        end
    end

    // R7
    gate_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o |-> busy_o);

    // R7
    busy_opens_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> gate_o);

    // R5
    single_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_p1_o && fault_p2_o));

    // R5
    fault_latch_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fault_p1_o) || $rose(fault_p2_o)) |-> (!gate_o && busy_o));

    // R4
    desat_cuts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(desat_i) && $past(desat_i, 2)) |-> !gate_o);

    // R6
    two_pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rises_q <= 3'd2);
endmodule

bind dpt_sequencer dpt_sequencer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .desat_i    (desat_i),
    .gate_o     (gate_o),
    .busy_o     (busy_o),
    .fault_p1_o (fault_p1_o),
    .fault_p2_o (fault_p2_o)
);

// File: tb/tb_dpt_sequencer.sv
// Bench for dpt_sequencer: a table of burst vectors followed by directed
// tests. Inputs change after a falling edge and outputs are sampled there.
module tb_dpt_sequencer;
    localparam int LOCK = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       start = 1'b0;
    logic       desat = 1'b0;
    logic [9:0] w1 = 10'd3;
    logic [6:0] w2 = 7'd3;
    logic       en2 = 1'b1;
    logic       gate, busy, f1, f2;

    int n_chk = 0;
    int n_bad = 0;
    int tick_div = 1;
    int tick_cnt = 0;

    always #5 clk = ~clk;

    dpt_sequencer #(.LOCKOUT_TICKS(LOCK)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .us_tick_i      (tick),
        .start_btn_i    (start),
        .desat_i        (desat),
        .pulse1_width_i (w1),
        .pulse2_width_i (w2),
        .pulse2_en_i    (en2),
        .gate_o         (gate),
        .busy_o         (busy),
        .fault_p1_o     (f1),
        .fault_p2_o     (f2)
    );

    // Purpose: tick generator, one pulse every tick_div clocks.
    always @(negedge clk) begin
        if (tick_cnt + 1 >= tick_div) begin
            tick     <= 1'b1;
            tick_cnt <= 0;
        end else begin
            tick     <= 1'b0;
            tick_cnt <= tick_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Runs one burst from a button press and measures the gate runs.
    task automatic burst(input int p1, input int p2, input bit en, input bit hold,
                         output int h1, output int gp, output int h2,
                         output int rises, output int lockc);
        bit seen, prev;
        int low;
        h1 = 0; gp = 0; h2 = 0; rises = 0; lockc = 0;
        seen = 0; prev = 0; low = 0;
        @(negedge clk);
        w1 = 10'(p1); w2 = 7'(p2); en2 = en; start = 1'b1;
        for (int i = 0; i < 8000; i++) begin
            @(negedge clk);
            if (busy) seen = 1;
            if (seen && !busy) break;
            if (gate && !prev) begin
                rises++;
                if (rises == 2) gp = low;
                low = 0;
            end
            if (gate) begin
                if (rises == 1) h1++; else h2++;
            end else if (busy) low++;
            prev = gate;
        end
        lockc = low;
        if (!hold) start = 1'b0;
    endtask

    localparam int NV = 6;
    // {pulse1 setting, pulse2 setting, enable, exp high1, exp gap, exp high2}
    localparam int VEC [NV][6] = '{
        '{3,    3,   1, 3,   3,   3},
        '{10,   5,   1, 10,  5,   5},
        '{1,    0,   1, 3,   3,   3},
        '{1023, 127, 1, 999, 100, 100},
        '{20,   8,   0, 20,  0,   0},
        '{7,    2,   0, 7,   0,   0}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int h1, gp, h2, rs, lk, n;
        bit ok;
        // R9: reset state
        cycles(4);
        check(!gate && !busy && !f1 && !f2, "R9 reset outputs", {gate, busy, f1, f2}, 0);
        rst_n = 1'b1;
        cycles(3);

        // R1 R2 R3 R7: vector table
        for (int v = 0; v < NV; v++) begin
            burst(VEC[v][0], VEC[v][1], VEC[v][2] != 0, 0, h1, gp, h2, rs, lk);
            check(h1 == VEC[v][3], "R1 first pulse width", h1, VEC[v][3]);
            check(gp == VEC[v][4], "R2 gap width", gp, VEC[v][4]);
            check(h2 == VEC[v][5], "R2 R3 second pulse width", h2, VEC[v][5]);
            check(rs == (VEC[v][2] != 0 ? 2 : 1), "R3 R6 pulse count", rs, VEC[v][2] != 0 ? 2 : 1);
            check(lk == LOCK, "R7 lockout length", lk, LOCK);
            cycles(3);
        end

        // R10: start latency
        @(negedge clk);
        w1 = 10'd5; w2 = 7'd3; en2 = 1'b0; start = 1'b1;
        n = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            n++;
            if (gate) break;
        end
        check(n == 3, "R10 start to gate latency", n, 3);
        start = 1'b0;
        while (busy) @(negedge clk);
        cycles(3);

        // R4 R5: desat during first pulse
        @(negedge clk);
        w1 = 10'd30; en2 = 1'b1; w2 = 7'd5; start = 1'b1;
        while (!gate) @(negedge clk);
        cycles(2);
        desat = 1'b1;
        cycles(1);
        check(gate, "R4 gate before sync done", gate, 1);
        cycles(1);
        check(!gate, "R4 gate cut after two edges", gate, 0);
        cycles(2);
        check(f1 && !f2 && busy, "R5 first pulse fault flag", {f1, f2, busy}, 3'b101);
        start = 1'b0;
        ok = 1;
        while (busy) begin @(negedge clk); if (gate) ok = 0; end
        check(ok, "R4 no pulse after abort", !ok, 0);
        check(f1, "R5 flag latched in idle", f1, 1);

        // R8: start ignored while desat held
        @(negedge clk);
        start = 1'b1;
        cycles(8);
        check(!busy && !gate, "R8 start blocked by desat", busy, 0);
        check(f1 && !f2, "R8 flags unchanged", {f1, f2}, 2'b10);
        start = 1'b0; desat = 1'b0;
        cycles(4);

        // R5: desat in the gap, no second pulse
        @(negedge clk);
        w1 = 10'd5; w2 = 7'd20; en2 = 1'b1; start = 1'b1;
        while (!gate) @(negedge clk);
        cycles(2);
        check(!f1 && !f2, "R5 flags cleared by accepted start", {f1, f2}, 0);
        while (gate) @(negedge clk);
        cycles(3);
        desat = 1'b1;
        ok = 1;
        while (busy) begin @(negedge clk); if (gate) ok = 0; end
        check(ok, "R5 second pulse suppressed after gap fault", !ok, 0);
        check(f1 && !f2, "R5 gap fault counts as first", {f1, f2}, 2'b10);
        start = 1'b0; desat = 1'b0;
        cycles(4);

        // R5: desat during second pulse
        @(negedge clk);
        w1 = 10'd4; w2 = 7'd30; en2 = 1'b1; start = 1'b1;
        while (!gate) @(negedge clk);
        while (gate) @(negedge clk);
        while (!gate) @(negedge clk);
        cycles(3);
        desat = 1'b1;
        cycles(4);
        check(!gate && f2 && !f1, "R5 second pulse fault flag", {gate, f1, f2}, 3'b001);
        start = 1'b0;
        while (busy) @(negedge clk);
        desat = 1'b0;
        cycles(4);

        // R6: held button does not retrigger
        burst(4, 3, 1, 1, h1, gp, h2, rs, lk);
        check(rs == 2, "R6 held burst pulses", rs, 2);
        cycles(30);
        check(!busy, "R6 no retrigger while held", busy, 0);
        start = 1'b0;
        cycles(4);
        @(negedge clk);
        start = 1'b1;
        cycles(5);
        check(busy, "R6 fresh press accepted", busy, 0);
        start = 1'b0;
        while (busy) @(negedge clk);
        cycles(3);

        // R1 R2 R7: slower tick, widths scale with tick period
        tick_div = 3;
        burst(4, 3, 1, 0, h1, gp, h2, rs, lk);
        check(h1 >= 10 && h1 <= 12, "R1 first pulse with slow tick", h1, 12);
        check(gp == 9, "R2 gap with slow tick", gp, 9);
        check(h2 == 9, "R2 second pulse with slow tick", h2, 9);
        check(lk == 3 * LOCK, "R7 lockout with slow tick", lk, 3 * LOCK);
        tick_div = 1;
        cycles(5);

        // R9: reset mid-burst
        @(negedge clk);
        w1 = 10'd50; start = 1'b1;
        cycles(6);
        rst_n = 1'b0;
        cycles(1);
        check(!gate && !busy && !f1 && !f2, "R9 reset during burst", {gate, busy}, 0);
        start = 1'b0;
        rst_n = 1'b1;
        cycles(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule